// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses the two source operands for the execute stage of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. It compares the source register numbers of the instruction entering execute with the destination registers of the two older instructions. Those destinations are held in the execute/memory latch and in the memory/writeback latch. When an older instruction will write a register that the current one reads (a read-after-write hazard), the selector forwards the newer value and does not use the stale register file read.

There are two bypass paths. The first carries the ALU result of the immediately preceding instruction, taken from the execute/memory latch. The second carries whatever the memory/writeback latch holds, which is either an ALU result or loaded data. A load is forwarded only from the memory/writeback latch, because loaded data is not available to the very next instruction. When that next instruction does read the load's destination, the selector raises a load-use flag. Stall generation, the register file and the ALU sit outside this block. The selection is purely combinational.

Top module: `opbyp_unit`

## Requirements
- R1: A source register number of 0 yields an operand of 32'h0, whatever the register file and the bypass inputs hold.
- R2: A nonzero source that matches no enabled latch destination takes its register file value.
- R3: A nonzero source equal to `exm_rd`, with `exm_wen`=1 and `exm_is_load`=0, takes `exm_alu_res`.
- R4: A nonzero source equal to `mwb_rd`, with `mwb_wen`=1 and no R3 match, takes `mwb_data`. This applies whether or not the producer was a load.
- R5: When a source matches both latches under R3 and R4, the execute/memory value wins.
- R6: A latch whose write enable is 0 never supplies an operand and never raises the load-use flag, even when its destination equals the source.
- R7: When `exm_wen`=1, `exm_is_load`=1 and `exm_rd` equals a nonzero source of either operand, `load_use` is 1. That operand then ignores `exm_alu_res` and falls back to the R4 or R2 choice.
- R8: `load_use` is 0 in every case that does not meet the R7 condition, including a load that targets register 0.
- R9: Operands A and B are selected independently by the same rules. Outputs follow input changes within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the instruction in execute |
| ex_src_b | input | 5 | Second source register number of the instruction in execute |
| rf_val_a | input | 32 | Register file read value for source A |
| rf_val_b | input | 32 | Register file read value for source B |
| exm_rd | input | 5 | Destination register held in the execute/memory latch |
| exm_wen | input | 1 | Register-write enable of the execute/memory instruction |
| exm_is_load | input | 1 | Execute/memory instruction is a load |
| exm_alu_res | input | 32 | ALU result held in the execute/memory latch |
| mwb_rd | input | 5 | Destination register held in the memory/writeback latch |
| mwb_wen | input | 1 | Register-write enable of the memory/writeback instruction |
| mwb_data | input | 32 | Value to be written back (ALU result or loaded data) |
| opnd_a | output | 32 | Selected operand A for the ALU |
| opnd_b | output | 32 | Selected operand B for the ALU |
| load_use | output | 1 | Instruction in execute reads the destination of a load one slot ahead |

## Verification
The block holds no state, so any wrong decision in its selection logic appears on `opnd_a`, `opnd_b` or `load_use` in the same cycle as the input pattern that exposes it. A wrong priority shows only when both latches name the same register. A missed load qualification shows as an ALU value forwarded while `load_use` is high. The stimulus therefore draws register numbers from a narrow range, so that double matches, register-0 sources and disabled writers occur often. Directed cases pin down each of these corners.

// File: rtl/opbyp_pkg.sv
// Package: shared types for the operand bypass selector.
// Assumes a 2-bit selection code is enough for the four operand sources.
package opbyp_pkg;

    // Which input feeds an operand.
    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_ALU  = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_ZERO = 2'd3
    } src_sel_e;

endpackage

// File: rtl/opbyp_match.sv
// Module: opbyp_match
// Decides where one source operand comes from by comparing its register number
// with the two latch destinations. Youngest producer wins; a load in the
// execute/memory latch is never forwarded and is reported instead.
// Assumes register 0 is hard-wired to zero.
module opbyp_match
    import opbyp_pkg::*;
#(
    parameter int RADDR_W = 5
) (
    input  logic [RADDR_W-1:0] src,
    input  logic [RADDR_W-1:0] exm_rd,
    input  logic               exm_wen,
    input  logic               exm_is_load,
    input  logic [RADDR_W-1:0] mwb_rd,
    input  logic               mwb_wen,
    output src_sel_e           sel,
    output logic               load_hit
);

    localparam logic [RADDR_W-1:0] ZERO_REG = '0;

    logic src_live;
    logic exm_hit;
    logic mwb_hit;

    // Raw register-number comparisons qualified by write enables.
    always_comb begin
        src_live = (src != ZERO_REG);
        exm_hit  = src_live && exm_wen && (exm_rd == src);
        mwb_hit  = src_live && mwb_wen && (mwb_rd == src);
        load_hit = exm_hit && exm_is_load;
    end

    // Priority selection: zero, then ALU bypass, then memory bypass, then file.
    always_comb begin
        if (!src_live) begin
            sel = SRC_ZERO;
        end else if (exm_hit && !exm_is_load) begin
            sel = SRC_ALU;
        end else if (mwb_hit) begin
            sel = SRC_MEM;
        end else begin
            sel = SRC_RF;
        end
    end

endmodule

// File: rtl/opbyp_mux.sv
// Module: opbyp_mux
// Four-way operand multiplexer steered by a selection code.
// Assumes the zero source needs no data input.
module opbyp_mux
    import opbyp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  src_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] alu_val,
    input  logic [DATA_W-1:0] mem_val,
    output logic [DATA_W-1:0] opnd
);

    // Route the selected candidate to the operand output.
    always_comb begin
        unique case (sel)
            SRC_ALU:  opnd = alu_val;
            SRC_MEM:  opnd = mem_val;
            SRC_ZERO: opnd = '0;
            default:  opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/opbyp_unit.sv
// Module: opbyp_unit (top)
// Selects both execute-stage operands from the register file and the two
// bypass paths, and flags a use of a load result one slot too early.
// Purely combinational; stall generation is left to the surrounding logic.
module opbyp_unit
    import opbyp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RADDR_W = 5
) (
    input  logic [RADDR_W-1:0] ex_src_a,
    input  logic [RADDR_W-1:0] ex_src_b,
    input  logic [DATA_W-1:0]  rf_val_a,
    input  logic [DATA_W-1:0]  rf_val_b,
    input  logic [RADDR_W-1:0] exm_rd,
    input  logic               exm_wen,
    input  logic               exm_is_load,
    input  logic [DATA_W-1:0]  exm_alu_res,
    input  logic [RADDR_W-1:0] mwb_rd,
    input  logic               mwb_wen,
    input  logic [DATA_W-1:0]  mwb_data,
    output logic [DATA_W-1:0]  opnd_a,
    output logic [DATA_W-1:0]  opnd_b,
    output logic               load_use
);

    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][RADDR_W-1:0] src_vec;
    logic [NUM_SRC-1:0][DATA_W-1:0]  rf_vec;
    logic [NUM_SRC-1:0][DATA_W-1:0]  opnd_vec;
    logic [NUM_SRC-1:0]              hit_vec;
    src_sel_e                        sel_vec [NUM_SRC];

    // Gather per-operand inputs into vectors for the generate loop.
    always_comb begin
        src_vec[0] = ex_src_a;
        src_vec[1] = ex_src_b;
        rf_vec[0]  = rf_val_a;
        rf_vec[1]  = rf_val_b;
    end

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        opbyp_match #(.RADDR_W(RADDR_W)) u_match (
            .src         (src_vec[gi]),
            .exm_rd      (exm_rd),
            .exm_wen     (exm_wen),
            .exm_is_load (exm_is_load),
            .mwb_rd      (mwb_rd),
            .mwb_wen     (mwb_wen),
            .sel         (sel_vec[gi]),
            .load_hit    (hit_vec[gi])
        );

        opbyp_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_vec[gi]),
            .rf_val  (rf_vec[gi]),
            .alu_val (exm_alu_res),
            .mem_val (mwb_data),
            .opnd    (opnd_vec[gi])
        );
    end

    // Drive the outputs from the per-operand results.
    always_comb begin
        opnd_a   = opnd_vec[0];
        opnd_b   = opnd_vec[1];
        load_use = |hit_vec;
    end

endmodule

// File: rtl/opbyp_unit_chk.sv
// Module: opbyp_unit_chk
// Port-level checks for opbyp_unit, attached by bind. Checks are skipped
// while any input is still unknown.
module opbyp_unit_chk #(
    parameter int DATA_W  = 32,
    parameter int RADDR_W = 5
) (
    input logic [RADDR_W-1:0] ex_src_a,
    input logic [RADDR_W-1:0] ex_src_b,
    input logic [DATA_W-1:0]  rf_val_a,
    input logic [DATA_W-1:0]  rf_val_b,
    input logic [RADDR_W-1:0] exm_rd,
    input logic               exm_wen,
    input logic               exm_is_load,
    input logic [DATA_W-1:0]  exm_alu_res,
    input logic [RADDR_W-1:0] mwb_rd,
    input logic               mwb_wen,
    input logic [DATA_W-1:0]  mwb_data,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b,
    input logic               load_use
);

    logic known;
    logic a_exm, a_mwb, b_exm, b_mwb;

    // Qualify checks on fully defined inputs and form per-source match flags.
    always_comb begin
        known = !$isunknown({ex_src_a, ex_src_b, rf_val_a, rf_val_b, exm_rd,
                             exm_wen, exm_is_load, exm_alu_res, mwb_rd,
                             mwb_wen, mwb_data});
        a_exm = (ex_src_a != '0) && exm_wen && (exm_rd == ex_src_a);
        a_mwb = (ex_src_a != '0) && mwb_wen && (mwb_rd == ex_src_a);
        b_exm = (ex_src_b != '0) && exm_wen && (exm_rd == ex_src_b);
        b_mwb = (ex_src_b != '0) && mwb_wen && (mwb_rd == ex_src_b);
    end

    // Immediate checks on the operand and flag outputs.
    always_comb begin
        if (known) begin
            p_zero_src_r1: assert (ex_src_a != '0 || opnd_a == '0);
            p_rf_default_r2: assert (a_exm || a_mwb || ex_src_a == '0
                                     || opnd_a == rf_val_a);
            p_alu_fwd_r5: assert (!(a_exm && !exm_is_load) || opnd_a == exm_alu_res);
            p_mem_fwd_r4: assert (!(b_mwb && !(b_exm && !exm_is_load))
                                  || opnd_b == mwb_data);
            p_load_flag_r7: assert (load_use == ((a_exm || b_exm) && exm_is_load));
        end
    end

endmodule

bind opbyp_unit opbyp_unit_chk #(.DATA_W(DATA_W), .RADDR_W(RADDR_W)) u_chk (.*);

// File: tb/tb_opbyp_unit.sv
// Bench for opbyp_unit: directed corners plus seeded random patterns,
// compared against a reference function built from the requirements.
module tb_opbyp_unit;

    localparam int CLK_PERIOD = 10;
    localparam int RANDOM_N   = 3000;

    logic        clk = 1'b0;
    logic [4:0]  ex_src_a, ex_src_b, exm_rd, mwb_rd;
    logic [31:0] rf_val_a, rf_val_b, exm_alu_res, mwb_data;
    logic        exm_wen, exm_is_load, mwb_wen;
    logic [31:0] opnd_a, opnd_b;
    logic        load_use;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    opbyp_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference operand value for one source.
    function automatic logic [31:0] ref_opnd(logic [4:0] s, logic [31:0] rf);
        if (s == 5'd0) return 32'h0;
        if (exm_wen && exm_rd == s && !exm_is_load) return exm_alu_res;
        if (mwb_wen && mwb_rd == s) return mwb_data;
        return rf;
    endfunction

    // Requirement that governs one source's choice.
    function automatic string ref_tag(logic [4:0] s);
        logic e, m;
        e = exm_wen && exm_rd == s;
        m = mwb_wen && mwb_rd == s;
        if (s == 5'd0) return "R1";
        if (e && exm_is_load) return "R7";
        if (e && m) return "R5";
        if (e) return "R3";
        if (m) return "R4";
        if ((exm_rd == s) || (mwb_rd == s)) return "R6";
        return "R2";
    endfunction

    function automatic logic ref_flag();
        return exm_wen && exm_is_load &&
               ((ex_src_a != 0 && exm_rd == ex_src_a) ||
                (ex_src_b != 0 && exm_rd == ex_src_b));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare all outputs against the reference at the falling edge.
    task automatic check_all(string note);
        @(negedge clk);
        check({ref_tag(ex_src_a), " opnd_a ", note}, opnd_a, ref_opnd(ex_src_a, rf_val_a));
        check({ref_tag(ex_src_b), " opnd_b R9 ", note}, opnd_b, ref_opnd(ex_src_b, rf_val_b));
        check({ref_flag() ? "R7" : "R8", " load_use ", note}, {31'b0, load_use},
              {31'b0, ref_flag()});
    endtask

    task automatic drive(logic [4:0] sa, logic [4:0] sb, logic [4:0] er, logic ew,
                         logic el, logic [4:0] mr, logic mw);
        @(posedge clk);
        ex_src_a = sa; ex_src_b = sb;
        exm_rd = er; exm_wen = ew; exm_is_load = el;
        mwb_rd = mr; mwb_wen = mw;
        rf_val_a = 32'hA0A0_0001; rf_val_b = 32'hB0B0_0002;
        exm_alu_res = 32'hE1E1_1111; mwb_data = 32'hD2D2_2222;
    endtask

    initial begin
        // Idle pattern: everything zero, all operands zero, no flag.
        drive(0, 0, 0, 0, 0, 0, 0);
        rf_val_a = 0; rf_val_b = 0; exm_alu_res = 0; mwb_data = 0;
        check_all("idle");
        // R1: register 0 with every path pointing at it.
        drive(0, 0, 0, 1, 0, 0, 1);       check_all("r1 zero");
        drive(0, 0, 0, 1, 1, 0, 1);       check_all("r1_r8 load to r0");
        // R2: no match.
        drive(3, 4, 5, 1, 0, 6, 1);       check_all("r2 no match");
        // R3: ALU bypass on A, file on B.
        drive(7, 8, 7, 1, 0, 9, 1);       check_all("r3 alu");
        // R4: memory bypass on B.
        drive(1, 9, 2, 1, 0, 9, 1);       check_all("r4 mem");
        // R5: both latches match A and B.
        drive(12, 12, 12, 1, 0, 12, 1);   check_all("r5 priority");
        // R6: disabled writers.
        drive(12, 13, 12, 0, 0, 13, 0);   check_all("r6 wen off");
        drive(12, 12, 12, 0, 1, 12, 1);   check_all("r6 load wen off");
        // R7: load in execute/memory, fall back to memory latch or file.
        drive(20, 21, 20, 1, 1, 20, 1);   check_all("r7 load fallback mem");
        drive(22, 20, 20, 1, 1, 3, 1);    check_all("r7 load fallback rf on B");
        // R8: load targeting an unrelated register.
        drive(2, 3, 4, 1, 1, 2, 1);       check_all("r8 no use");
        // R9: output follows an input change in the same cycle.
        drive(7, 7, 7, 1, 0, 0, 0);
        #1 exm_alu_res = 32'h1234_5678;
        #1 check("R9 same-cycle", opnd_a, 32'h1234_5678);
        check_all("r9 follow");

        // Random patterns with a narrow register range to force collisions.
        void'($urandom(32'd2024));
        for (int i = 0; i < RANDOM_N; i++) begin
            @(posedge clk);
            ex_src_a    = 5'($urandom_range(0, 3));
            ex_src_b    = 5'($urandom_range(0, 3));
            exm_rd      = 5'($urandom_range(0, 3));
            mwb_rd      = 5'($urandom_range(0, 3));
            exm_wen     = 1'($urandom);
            mwb_wen     = 1'($urandom);
            exm_is_load = 1'($urandom_range(0, 3) == 0);
            rf_val_a    = $urandom;
            rf_val_b    = $urandom;
            exm_alu_res = $urandom;
            mwb_data    = $urandom;
            check_all("random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule